// File: doc/BRIEF.md
# Three-Cell Bidirectional Pad Scan Register

This block is the boundary data register for a row of bidirectional pads. Every pad owns three scan cells, always present whatever the pad is used for. The first cell observes the pad's input value. The second holds the value the pad drives. The third holds the pad's output enable. Each cell pairs a capture/shift flop with a separate update flop. The update flop changes only on the update strobe, so shifting never disturbs whatever the update stage is driving.

The block sits between the core logic and the pad drivers. A test access port controller outside the block supplies the capture, shift and update strobes and a decoded two-bit instruction mode. The block then does one of the following:
- Observes the running system without touching it.
- Takes over the pad drivers from the core.
- Feeds the core's input pins from scanned values.

When no boundary instruction is selected, the block is invisible. The core connects straight to the pads and all scan state holds.

Top module: `bsr_pad_ring`

## Requirements
- R1: The chain holds 3×PADS cells. Pad p occupies positions 3p (input cell), 3p+1 (output cell) and 3p+2 (enable cell), with position 0 nearest tdi. tdo always shows the last position (the enable cell of pad PADS-1). Each enabled shift edge moves the chain one position toward tdo and loads tdi into position 0.
- R2: On an enabled capture edge, each input cell loads pad_in[p], each output cell loads core_out[p] and each enable cell loads core_oe[p]. Capture takes priority over shift when both strobes are high.
- R3: The update stage loads the whole chain only on an enabled update edge. Shifting alone leaves the update stage, and therefore the pins, unchanged.
- R4: In sample/preload mode (mode=2'b01), pad_out and pad_oe follow the core and core_in follows pad_in, even after capture, shift or update.
- R5: In external-test mode (mode=2'b10), pad_oe[p] is the updated enable cell and pad_out[p] is the updated output cell. The core's drive is ignored.
- R6: In internal-test mode (mode=2'b11), core_in[p] is the updated input cell while the pads stay driven by the core. In every other mode, core_in equals pad_in.
- R7: In normal mode (mode=2'b00), the capture, shift and update strobes have no effect. The chain and the update stage keep their contents, and the core drives the pads directly.
- R8: A pad is driven only when its selected enable is 1. When the enable is 0, pad_out reads 0 and the pad driver is released (high impedance).
- R9: While trst_n is low, every chain cell and every update cell is 0. Reset is applied asynchronously and released on the clock, two edges after trst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Decoded instruction: 00 normal, 01 sample/preload, 10 external test, 11 internal test |
| capture_dr | input | 1 | Capture strobe from the controller |
| shift_dr | input | 1 | Shift strobe from the controller |
| update_dr | input | 1 | Update strobe from the controller |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| pad_in | input | PADS | Values received at the pads |
| pad_out | output | PADS | Values driven toward the pads (0 when not enabled) |
| pad_oe | output | PADS | Active-high pad driver enables |
| core_out | input | PADS | Core's output values |
| core_oe | input | PADS | Core's output enables |
| core_in | output | PADS | Pad values as seen by the core |

## Verification
A fault in the capture/shift stage shows up only at tdo. It appears after the shift that brings the bad cell to the end of the chain, which can take up to 3×PADS edges. The bench therefore shifts out the whole chain after every capture and compares it bit by bit. A fault in the update stage shows up at once on pad_out, pad_oe or core_in, but only while external-test or internal-test mode is selected. The bench enters those modes after each update, and after every period in which the update stage is expected to hold.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    BSR_NORMAL = 2'b00,
    BSR_SAMPLE = 2'b01,
    BSR_EXTEST = 2'b10,
    BSR_INTEST = 2'b11
  } bsr_mode_e;

  localparam int CELLS_PER_PAD = 3;
  localparam int CELL_IN  = 0;
  localparam int CELL_OUT = 1;
  localparam int CELL_EN  = 2;

  function automatic int cell_pos(input int pad, input int kind);
    return pad * CELLS_PER_PAD + kind;
  endfunction
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/bsr_capture_chain.sv
module bsr_capture_chain
  import bsr_pkg::*;
#(
  parameter int PADS = 4,
  localparam int LEN = PADS * CELLS_PER_PAD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            tdi,
  input  logic [PADS-1:0] pad_in,
  input  logic [PADS-1:0] core_out,
  input  logic [PADS-1:0] core_oe,
  output logic [LEN-1:0]  chain_q,
  output logic            tdo
);
  logic [LEN-1:0] chain_d;
  logic [LEN-1:0] capt_vec;

  always_comb begin
    capt_vec = '0;
    for (int p = 0; p < PADS; p++) begin
      capt_vec[cell_pos(p, CELL_IN)]  = pad_in[p];
      capt_vec[cell_pos(p, CELL_OUT)] = core_out[p];
      capt_vec[cell_pos(p, CELL_EN)]  = core_oe[p];
    end
  end

  always_comb begin
    chain_d = chain_q;
    if (cap_en)        chain_d = capt_vec;
    else if (shift_en) chain_d = {chain_q[LEN-2:0], tdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign tdo = chain_q[LEN-1];

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !shift_en) |=> $stable(chain_q)) else $error("chain moved"); // R7
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (chain_q[0] == $past(tdi))) else $error("tdi lost"); // R1
  AST_SHIFT_TDO: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (tdo == $past(chain_q[LEN-2]))) else $error("tdo order"); // R1
endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank
  import bsr_pkg::*;
#(
  parameter int PADS = 4,
  localparam int LEN = PADS * CELLS_PER_PAD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [LEN-1:0]  chain_q,
  output logic [PADS-1:0] upd_in,
  output logic [PADS-1:0] upd_out,
  output logic [PADS-1:0] upd_oe
);
  for (genvar p = 0; p < PADS; p++) begin : g_pad
    logic [CELLS_PER_PAD-1:0] cell_q;
    logic [CELLS_PER_PAD-1:0] cell_d;

    always_comb begin
      cell_d = cell_q;
      if (upd_en) cell_d = chain_q[p*CELLS_PER_PAD +: CELLS_PER_PAD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= '0;
      else        cell_q <= cell_d;
    end

    assign upd_in[p]  = cell_q[CELL_IN];
    assign upd_out[p] = cell_q[CELL_OUT];
    assign upd_oe[p]  = cell_q[CELL_EN];
  end

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable({upd_in, upd_out, upd_oe})) else $error("update moved"); // R3
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int PADS = 4
) (
  input  bsr_mode_e       mode,
  input  logic [PADS-1:0] pad_in,
  input  logic [PADS-1:0] core_out,
  input  logic [PADS-1:0] core_oe,
  input  logic [PADS-1:0] upd_in,
  input  logic [PADS-1:0] upd_out,
  input  logic [PADS-1:0] upd_oe,
  output logic [PADS-1:0] pad_out,
  output logic [PADS-1:0] pad_oe,
  output logic [PADS-1:0] core_in
);
  logic ext_sel;
  logic int_sel;

  always_comb begin
    ext_sel = (mode == BSR_EXTEST);
    int_sel = (mode == BSR_INTEST);
  end

  for (genvar p = 0; p < PADS; p++) begin : g_mux
    logic drv_val;
    logic drv_en;
    always_comb begin
      drv_val    = ext_sel ? upd_out[p] : core_out[p];
      drv_en     = ext_sel ? upd_oe[p]  : core_oe[p];
      pad_oe[p]  = drv_en;
      pad_out[p] = drv_val & drv_en;
      core_in[p] = int_sel ? upd_in[p] : pad_in[p];
    end
  end
endmodule

// File: rtl/bsr_pad_ring.sv
module bsr_pad_ring
  import bsr_pkg::*;
#(
  parameter int PADS = 4,
  localparam int LEN = PADS * CELLS_PER_PAD
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic [1:0]      mode,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  input  logic [PADS-1:0] pad_in,
  output logic [PADS-1:0] pad_out,
  output logic [PADS-1:0] pad_oe,
  input  logic [PADS-1:0] core_out,
  input  logic [PADS-1:0] core_oe,
  output logic [PADS-1:0] core_in
);
  logic            rst_n;
  bsr_mode_e       mode_e;
  logic            bnd_sel;
  logic            cap_en;
  logic            shift_en;
  logic            upd_en;
  logic [LEN-1:0]  chain_q;
  logic [PADS-1:0] upd_in;
  logic [PADS-1:0] upd_out;
  logic [PADS-1:0] upd_oe;

  always_comb begin
    mode_e   = bsr_mode_e'(mode);
    bnd_sel  = (mode_e != BSR_NORMAL);
    cap_en   = bnd_sel & capture_dr;
    shift_en = bnd_sel & shift_dr & ~capture_dr;
    upd_en   = bnd_sel & update_dr;
  end

  bsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n_o(rst_n)
  );

  bsr_capture_chain #(.PADS(PADS)) u_chain (
    .clk(tck), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
    .tdi(tdi), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .chain_q(chain_q), .tdo(tdo)
  );

  bsr_update_bank #(.PADS(PADS)) u_upd (
    .clk(tck), .rst_n(rst_n), .upd_en(upd_en), .chain_q(chain_q),
    .upd_in(upd_in), .upd_out(upd_out), .upd_oe(upd_oe)
  );

  bsr_pin_mux #(.PADS(PADS)) u_mux (
    .mode(mode_e), .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .upd_in(upd_in), .upd_out(upd_out), .upd_oe(upd_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  AST_PAD_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0)) else $error("undriven pad toggles"); // R8
  AST_CORE_DIRECT: assert property (@(posedge tck) disable iff (!rst_n)
    (mode != 2'b11) |-> (core_in == pad_in)) else $error("core isolated"); // R6
  AST_SAMPLE_PINS: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == 2'b01) |-> (pad_oe == core_oe)) else $error("sample intrusive"); // R4
  AST_NORMAL_FREEZE: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == 2'b00) |=> ($stable(chain_q) && $stable(upd_oe))) else $error("normal moved"); // R7
endmodule

// File: tb/bsr_pad_ring_test.sv
module bsr_pad_ring_test;
  localparam int P = 4;
  localparam int N = 3 * P;

  typedef struct packed {
    logic [P-1:0] pin;
    logic [P-1:0] cout;
    logic [P-1:0] coe;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{pin: 4'b1010, cout: 4'b0101, coe: 4'b1100},
    '{pin: 4'b0001, cout: 4'b1111, coe: 4'b1000},
    '{pin: 4'b1111, cout: 4'b0000, coe: 4'b0111},
    '{pin: 4'b0110, cout: 4'b1001, coe: 4'b0001}
  };

  logic tck = 0;
  logic trst_n;
  logic [1:0] mode;
  logic capture_dr, shift_dr, update_dr, tdi;
  logic tdo;
  logic [P-1:0] pad_in, pad_out, pad_oe, core_out, core_oe, core_in;

  int errors = 0;
  int checks = 0;

  always #2 tck = ~tck;

  bsr_pad_ring #(.PADS(P)) uut (
    .tck(tck), .trst_n(trst_n), .mode(mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mk(input logic [P-1:0] pin,
                                      input logic [P-1:0] cout,
                                      input logic [P-1:0] coe);
    logic [N-1:0] v;
    for (int p = 0; p < P; p++) begin
      v[3*p]   = pin[p];
      v[3*p+1] = cout[p];
      v[3*p+2] = coe[p];
    end
    return v;
  endfunction

  task automatic cyc();
    @(posedge tck);
    #1;
  endtask

  task automatic shift_chain(input logic [N-1:0] vin, output logic [N-1:0] vout);
    for (int i = 0; i < N; i++) begin
      tdi = vin[N-1-i];
      vout[N-1-i] = tdo;
      shift_dr = 1'b1;
      cyc();
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic pulse_cap();
    capture_dr = 1'b1; cyc(); capture_dr = 1'b0;
  endtask

  task automatic pulse_upd();
    update_dr = 1'b1; cyc(); update_dr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] got, pv, qv;
    trst_n = 1'b0; mode = 2'b10; capture_dr = 0; shift_dr = 0; update_dr = 0;
    tdi = 0; pad_in = '0; core_out = '1; core_oe = '1;
    repeat (3) cyc();
    chk("R9 tdo in reset", 32'(tdo), 0);
    chk("R9 pad_oe from cleared update", 32'(pad_oe), 0);
    chk("R8 pad_out gated", 32'(pad_out), 0);
    trst_n = 1'b1;
    repeat (3) cyc();

    // Table walk: sample/preload capture and full shift-out (R1, R2, R4)
    mode = 2'b01;
    for (int t = 0; t < 4; t++) begin
      pad_in = TBL[t].pin; core_out = TBL[t].cout; core_oe = TBL[t].coe;
      #1;
      chk("R4 pad_oe follows core", 32'(pad_oe), 32'(TBL[t].coe));
      chk("R4 pad_out follows core", 32'(pad_out), 32'(TBL[t].cout & TBL[t].coe));
      chk("R4 core_in follows pads", 32'(core_in), 32'(TBL[t].pin));
      pulse_cap();
      chk("R1 first tdo bit is last enable cell", 32'(tdo), 32'(TBL[t].coe[P-1]));
      shift_chain('0, got);
      chk("R2 captured chain", 32'(got), 32'(mk(TBL[t].pin, TBL[t].cout, TBL[t].coe)));
    end

    // Capture wins over shift (R2)
    pad_in = 4'b0011; core_out = 4'b1100; core_oe = 4'b1010;
    capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1; cyc();
    capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
    shift_chain('0, got);
    chk("R2 capture priority", 32'(got), 32'(mk(4'b0011, 4'b1100, 4'b1010)));

    // Preload then update, still transparent in sample (R4)
    core_out = 4'b1111; core_oe = 4'b1111; pad_in = 4'b0101;
    pv = mk(4'b1010, 4'b0110, 4'b0011);
    shift_chain(pv, got);
    pulse_upd();
    chk("R4 pins untouched after update", 32'(pad_out), 32'(4'b1111));
    mode = 2'b10; #1;
    chk("R5 extest enables", 32'(pad_oe), 32'(4'b0011));
    chk("R8 extest outputs gated", 32'(pad_out), 32'(4'b0010));
    chk("R6 core_in direct outside intest", 32'(core_in), 32'(4'b0101));

    // Shift without update leaves pins (R3)
    qv = mk(4'b0110, 4'b1101, 4'b1110);
    shift_chain(qv, got);
    chk("R1 preload returned after full shift", 32'(got), 32'(pv));
    chk("R3 pins hold during shift", 32'(pad_oe), 32'(4'b0011));
    pulse_upd();
    chk("R3 update applies enables", 32'(pad_oe), 32'(4'b1110));
    chk("R5 update applies outputs", 32'(pad_out), 32'(4'b1100));

    // Internal test (R6)
    mode = 2'b11; #1;
    chk("R6 core_in from update cells", 32'(core_in), 32'(4'b0110));
    chk("R6 pads from core in intest", 32'(pad_oe), 32'(4'b1111));

    // Normal mode ignores strobes (R7)
    mode = 2'b00; core_oe = 4'b0101; core_out = 4'b0100; pad_in = 4'b1001;
    pulse_cap();
    shift_chain('1, got);
    pulse_upd();
    chk("R7 core drives pads", 32'(pad_out), 32'(4'b0100));
    chk("R7 core_in direct", 32'(core_in), 32'(4'b1001));
    mode = 2'b10; #1;
    chk("R7 update stage held", 32'(pad_oe), 32'(4'b1110));
    mode = 2'b01;
    shift_chain('0, got);
    chk("R7 chain held", 32'(got), 32'(qv));

    // Asynchronous reset mid-run clears update stage (R9)
    mode = 2'b10;
    trst_n = 1'b0; #1;
    chk("R9 async clear", 32'(pad_oe), 0);
    cyc(); trst_n = 1'b1;
    shift_chain('1, got);
    chk("R9 chain cleared", 32'(got), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule